// File: doc/BRIEF.md
# DMA Interrupt and Channel-Enable Register Bank

This block is the interrupt and channel-enable register bank of a DMA controller with up to eight channels. The channel engines report events as one-cycle pulses, one vector per event group: transfer complete, block complete, source transaction done, destination transaction done and error. Each group latches its pulses into a raw register. It also has a mask register, a status view that is raw AND mask, and a write-only clear register. All unmasked pending events are merged into one registered interrupt line.

The same bank holds a global enable bit and a channel-enable register. The channel engines use the channel-enable vector to decide which channels may run. A channel's enable bit drops by itself when that channel reports transfer completion. The mask and channel-enable registers are written with a per-bit write-enable byte, so software can change some channels without a read-modify-write.

The register port is a simple 32-bit port with word addressing. A write takes effect at the clock edge where `wr_en_i` is high. Read data is combinational from `addr_i`.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset, every raw, mask, global-enable and channel-enable bit is 0. `irq_o` and `ch_en_o` are 0, and every register reads 0.
- R2: Group order is 0 = transfer complete, 1 = block complete, 2 = source transaction, 3 = destination transaction, 4 = error. The raw register of group g sits at word address g. A pulse on a channel's event input sets that channel's raw bit at the next clock edge, whatever the mask.
- R3: The status register of group g sits at word address 8+g. Each of its bits reads as the raw bit AND the mask bit.
- R4: The clear register of group g sits at word address 24+g. Writing a 1 in bit c clears raw bit c of that group, and writing a 0 leaves the bit unchanged. If an event for the same bit arrives in the same cycle, the raw bit stays set.
- R5: The mask register of group g sits at word address 16+g. A write changes mask bit c only when write-data bit 8+c is 1, and the bit then takes the value of write-data bit c.
- R6: Word address 32 reads the combined status. Bit g is 1 when any status bit of group g is 1.
- R7: `irq_o` is the OR of all status bits of all groups, registered. It follows a change in status one clock edge later.
- R8: Bit 0 of word address 33 is the global enable. While it is 0, the channel-enable register reads 0, `ch_en_o` is 0 and channel-enable writes have no effect.
- R9: The channel-enable register sits at word address 34 and uses the same write-enable rule as R5. `ch_en_o` and the readback show its value.
- R10: A transfer-complete pulse on channel c clears channel-enable bit c at the next edge. This clear wins over a same-cycle write that sets the bit.
- R11: Clear registers and unmapped addresses read 0. Read bits at or above the channel count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| evt_xfer_i | input | NUM_CH | Transfer-complete pulses |
| evt_block_i | input | NUM_CH | Block-complete pulses |
| evt_src_i | input | NUM_CH | Source-transaction pulses |
| evt_dst_i | input | NUM_CH | Destination-transaction pulses |
| evt_err_i | input | NUM_CH | Error pulses |
| irq_o | output | 1 | Combined interrupt, registered |
| ch_en_o | output | NUM_CH | Effective channel enables |

## Verification
A wrong raw or mask bit shows at once on the status and combined-status reads. It reaches `irq_o` exactly one edge after the status changes. A lost or stuck channel-enable bit shows on `ch_en_o` in the cycle after the write, the completion pulse or the global-enable change that should have moved it. The bench reads the registers back at those moments. It also drives the same-cycle cases where an event meets a clear write and where a completion pulse meets an enable write, because a wrong priority leaves a visibly different bit one cycle later.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int MAX_CH  = 8;
  localparam int NUM_GRP = 5;

  localparam int A_RAW  = 0;
  localparam int A_STAT = 8;
  localparam int A_MASK = 16;
  localparam int A_CLR  = 24;
  localparam int A_COMB = 32;
  localparam int A_GLOB = 33;
  localparam int A_CHEN = 34;

  typedef enum logic [2:0] {
    GRP_XFER  = 3'd0,
    GRP_BLOCK = 3'd1,
    GRP_SRC   = 3'd2,
    GRP_DST   = 3'd3,
    GRP_ERR   = 3'd4
  } grp_e;

  // bits 15:8 select which of bits 7:0 are written
  function automatic logic [MAX_CH-1:0] be_update(logic [MAX_CH-1:0] cur, logic [15:0] w);
    return (cur & ~w[15:8]) | (w[7:0] & w[15:8]);
  endfunction
endpackage

// File: rtl/dma_irq_group.sv
module dma_irq_group import dma_irq_pkg::*; #(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              clr_we_i,
  input  logic              mask_we_i,
  input  logic [15:0]       wdata_i,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] stat_o
);
  logic [NUM_CH-1:0] raw_q, mask_q, raw_d, mask_d, clr;
  logic [MAX_CH-1:0] mask_upd;

  assign clr      = clr_we_i ? wdata_i[NUM_CH-1:0] : '0;
  assign raw_d    = (raw_q & ~clr) | evt_i;  // new event beats clear
  assign mask_upd = be_update(MAX_CH'(mask_q), wdata_i);
  assign mask_d   = mask_we_i ? mask_upd[NUM_CH-1:0] : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign stat_o = raw_q & mask_q;
endmodule

// File: rtl/dma_ch_enable.sv
module dma_ch_enable import dma_irq_pkg::*; #(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glob_we_i,
  input  logic              chen_we_i,
  input  logic [15:0]       wdata_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic              glob_o,
  output logic [NUM_CH-1:0] chen_o
);
  logic              glob_q;
  logic [NUM_CH-1:0] chen_q, chen_d, chen_wr;
  logic [MAX_CH-1:0] chen_upd;

  assign chen_upd = be_update(MAX_CH'(chen_q), wdata_i);
  assign chen_wr  = chen_we_i ? chen_upd[NUM_CH-1:0] : chen_q;
  // controller off: hold all channels disabled, ignore writes
  assign chen_d   = glob_q ? (chen_wr & ~done_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_q <= 1'b0;
      chen_q <= '0;
    end else begin
      if (glob_we_i) glob_q <= wdata_i[0];
      chen_q <= chen_d;
    end
  end

  assign glob_o = glob_q;
  assign chen_o = chen_q & {NUM_CH{glob_q}};
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs import dma_irq_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_CH-1:0] evt_xfer_i,
  input  logic [NUM_CH-1:0] evt_block_i,
  input  logic [NUM_CH-1:0] evt_src_i,
  input  logic [NUM_CH-1:0] evt_dst_i,
  input  logic [NUM_CH-1:0] evt_err_i,
  output logic              irq_o,
  output logic [NUM_CH-1:0] ch_en_o
);
  localparam int FLAT_W = NUM_GRP * NUM_CH;

  logic [31:0] addr_w;
  logic [NUM_GRP-1:0][NUM_CH-1:0] evt, raw, mask, stat;
  logic [NUM_GRP-1:0] clr_we, mask_we, comb;
  logic [FLAT_W-1:0] evt_flat, raw_flat, mask_flat;
  logic glob, irq_q;
  logic [NUM_CH-1:0] chen;

  assign addr_w = 32'(addr_i);
  assign evt    = {evt_err_i, evt_dst_i, evt_src_i, evt_block_i, evt_xfer_i};

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign clr_we[g]  = wr_en_i && (addr_w == 32'(A_CLR + g));
    assign mask_we[g] = wr_en_i && (addr_w == 32'(A_MASK + g));
    assign comb[g]    = |stat[g];

    dma_irq_group #(.NUM_CH(NUM_CH)) u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt[g]),
      .clr_we_i (clr_we[g]),
      .mask_we_i(mask_we[g]),
      .wdata_i  (wdata_i[15:0]),
      .raw_o    (raw[g]),
      .mask_o   (mask[g]),
      .stat_o   (stat[g])
    );
  end

  dma_ch_enable #(.NUM_CH(NUM_CH)) u_chen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .glob_we_i(wr_en_i && (addr_w == 32'(A_GLOB))),
    .chen_we_i(wr_en_i && (addr_w == 32'(A_CHEN))),
    .wdata_i  (wdata_i[15:0]),
    .done_i   (evt_xfer_i),
    .glob_o   (glob),
    .chen_o   (chen)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |comb;
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (addr_w == 32'(A_RAW + g))  rdata_o[NUM_CH-1:0] = raw[g];
      if (addr_w == 32'(A_STAT + g)) rdata_o[NUM_CH-1:0] = stat[g];
      if (addr_w == 32'(A_MASK + g)) rdata_o[NUM_CH-1:0] = mask[g];
    end
    if (addr_w == 32'(A_COMB)) rdata_o[NUM_GRP-1:0] = comb;
    if (addr_w == 32'(A_GLOB)) rdata_o[0] = glob;
    if (addr_w == 32'(A_CHEN)) rdata_o[NUM_CH-1:0] = chen;
  end

  assign evt_flat  = evt;
  assign raw_flat  = raw;
  assign mask_flat = mask;
  assign irq_o     = irq_q;
  assign ch_en_o   = chen;
endmodule

// File: rtl/dma_irq_regs_chk.sv
module dma_irq_regs_chk import dma_irq_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 6
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_en_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [NUM_GRP*NUM_CH-1:0] evt_flat,
  input logic [NUM_GRP*NUM_CH-1:0] raw_flat,
  input logic [NUM_GRP*NUM_CH-1:0] mask_flat,
  input logic [NUM_CH-1:0]         evt_xfer_i,
  input logic                      glob,
  input logic                      irq_o,
  input logic [NUM_CH-1:0]         ch_en_o
);
  logic clr_hit;
  assign clr_hit = wr_en_i && (32'(addr_i) >= 32'(A_CLR)) && (32'(addr_i) < 32'(A_CLR + NUM_GRP));

  a_r2_event_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_flat != '0) |=> ((raw_flat & $past(evt_flat)) == $past(evt_flat)));

  a_r4_fall_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(raw_flat) & ~raw_flat) != '0) |-> $past(clr_hit));

  a_r7_irq_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(raw_flat & mask_flat)));

  a_r8_off_no_channels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob |-> (ch_en_o == '0));

  a_r10_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_xfer_i != '0) |=> ((ch_en_o & $past(evt_xfer_i)) == '0));
endmodule

bind dma_irq_regs dma_irq_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .evt_flat  (evt_flat),
  .raw_flat  (raw_flat),
  .mask_flat (mask_flat),
  .evt_xfer_i(evt_xfer_i),
  .glob      (glob),
  .irq_o     (irq_o),
  .ch_en_o   (ch_en_o)
);

// File: tb/sim_dma_irq_regs.sv
module sim_dma_irq_regs;
  localparam int NC = 8;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NC-1:0] e_xfer = '0, e_block = '0, e_src = '0, e_dst = '0, e_err = '0;
  logic irq;
  logic [NC-1:0] ch_en;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_irq_regs #(.NUM_CH(NC), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .evt_xfer_i(e_xfer), .evt_block_i(e_block), .evt_src_i(e_src),
    .evt_dst_i(e_dst), .evt_err_i(e_err), .irq_o(irq), .ch_en_o(ch_en)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  task automatic rd_chk(string req, int a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    for (int g = 0; g < 5; g++) begin
      rd_chk("R1 raw", g, 0);
      rd_chk("R1 mask", 16 + g, 0);
    end
    rd_chk("R1 glob", 33, 0);
    rd_chk("R1 chen", 34, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 ch_en_o", {24'd0, ch_en}, 0);
  endtask

  task automatic t_raw_mask();
    @(negedge clk); e_err = 8'h08;
    @(negedge clk); e_err = '0;
    rd_chk("R2 raw err", 4, 32'h08);
    rd_chk("R3 stat masked", 12, 0);
    @(negedge clk);
    chk("R7 irq masked", {31'd0, irq}, 0);
    rd_chk("R6 comb none", 32, 0);
    wr(20, 32'h0808);
    rd_chk("R3 stat err", 12, 32'h08);
    rd_chk("R6 comb err", 32, 32'h10);
    chk("R7 irq not yet", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R7 irq set", {31'd0, irq}, 1);
    wr(28, 32'h08);
    rd_chk("R4 err cleared", 4, 0);
    @(negedge clk);
    chk("R7 irq drop", {31'd0, irq}, 0);
  endtask

  task automatic t_mask_we();
    wr(17, 32'hFFAA);
    rd_chk("R5 all we", 17, 32'hAA);
    wr(17, 32'h0F00);
    rd_chk("R5 partial we", 17, 32'hA0);
    wr(17, 32'h0055);
    rd_chk("R5 no we", 17, 32'hA0);
  endtask

  task automatic t_clear();
    @(negedge clk); e_block = 8'h0F;
    @(negedge clk); e_block = '0;
    rd_chk("R2 raw block", 1, 32'h0F);
    rd_chk("R3 stat block", 9, 32'h0F & 32'hA0);
    wr(25, 32'h05);
    rd_chk("R4 clear ones", 1, 32'h0A);
    wr(25, 32'h00);
    rd_chk("R4 clear zeros", 1, 32'h0A);
    @(negedge clk);
    e_block = 8'h02; wr_en = 1'b1; addr = AW'(25); wdata = 32'h02;
    @(negedge clk);
    e_block = '0; wr_en = 1'b0; wdata = '0;
    rd_chk("R4 event wins", 1, 32'h0A);
    rd_chk("R11 clear reads 0", 25, 0);
  endtask

  task automatic t_chen();
    wr(34, 32'hFFFF);
    rd_chk("R8 off chen", 34, 0);
    chk("R8 off ch_en_o", {24'd0, ch_en}, 0);
    wr(33, 32'h1);
    rd_chk("R8 glob on", 33, 1);
    rd_chk("R8 write ignored", 34, 0);
    wr(34, 32'h0F0F);
    rd_chk("R9 chen", 34, 32'h0F);
    chk("R9 ch_en_o", {24'd0, ch_en}, 32'h0F);
    wr(34, 32'h3000);
    rd_chk("R9 no set w/o data", 34, 32'h0F);
    @(negedge clk); e_xfer = 8'h02;
    @(negedge clk); e_xfer = '0;
    chk("R10 done clears", {24'd0, ch_en}, 32'h0D);
    rd_chk("R2 raw xfer", 0, 32'h02);
    @(negedge clk);
    e_xfer = 8'h02; wr_en = 1'b1; addr = AW'(34); wdata = 32'h0202;
    @(negedge clk);
    e_xfer = '0; wr_en = 1'b0; wdata = '0;
    rd_chk("R10 done beats set", 34, 32'h0D);
    wr(33, 32'h0);
    rd_chk("R8 disabled", 34, 0);
    chk("R8 ch_en_o off", {24'd0, ch_en}, 0);
    wr(33, 32'h1);
    rd_chk("R8 stays cleared", 34, 0);
  endtask

  task automatic t_misc();
    @(negedge clk); e_src = 8'hFF; e_dst = 8'h81;
    @(negedge clk); e_src = '0; e_dst = '0;
    rd_chk("R11 upper bits src", 2, 32'hFF);
    rd_chk("R2 raw dst", 3, 32'h81);
    rd_chk("R11 unmapped", 40, 0);
    rd_chk("R11 unmapped 6", 6, 0);
    wr(19, 32'h0101);
    rd_chk("R6 comb dst", 32, 32'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_raw_mask();
    t_mask_we();
    t_clear();
    t_chen();
    t_misc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule